// File: doc/BRIEF.md
# Two-Group Priority Interrupt Controller

This block collects fifteen interrupt request lines, numbered 1 to 15, for one processor and presents a single encoded interrupt level plus a request flag. A rising edge on a request line records the line as pending. Software can also force lines on, and it can mask them, through a small word-addressed register bus. Each line belongs to one of two priority groups, chosen by a programmable group register. The high group always takes precedence over the low group. Within the chosen group, the highest-numbered line wins.

Mask, force and a small extended field are kept once per CPU. The number of CPUs is a parameter, and only CPU 0 drives the output. When a line's broadcast bit is set, its rising edge goes to the force register of every CPU instead of to the shared pending register. A processor acknowledge carries an interrupt number. It removes that line from the pending register and from the CPU 0 force register.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, `irq_level` is 0 and `irq_req` is low.
- R2: Bit 0 of the group, mask, force and broadcast registers always reads 0, and a set bit 0 in write data is dropped. Request line 0 never sets a pending bit.
- R3: The pending register (offset 0x04) is read-only, and writes to it change nothing. The clear offset (0x0C) and the status offset (0x10) always read 0.
- R4: Writing data D to offset 0x0C removes the bits of D[15:1] from both the pending register and the CPU 0 force register.
- R5: A write of data D to the force register of CPU n (offset 0x80+4n) gives new = (old | D[15:1]) & ~D[31:17]. Clear bit k sits at data bit k+16, so a clear wins over a set of the same bit in one word.
- R6: Offset 0x08 reads the CPU 0 force register. A write there replaces its bits 15:1 outright.
- R7: The active set is (pending | force0) & mask0, where mask0 is at offset 0x40. Lines with a 1 in the group register (offset 0x00) form the high group. `irq_level` is the highest-numbered active line of the high group when that group is non-empty, otherwise the highest of the low group, otherwise 0. It is registered one cycle after the state changes, and `irq_req` is 1 exactly when `irq_level` is non-zero.
- R8: When a request line rises and its bit is set in the broadcast register (offset 0x14), the line is set in every CPU's force register and pending stays unchanged.
- R9: An `ack_valid` cycle with number k in 1..15 clears bit k of pending and of force0.
- R10: The extended register of CPU n (offset 0xC0+4n) keeps only data bits 3:0. Mask, force and extended offsets for a CPU index at or above `NCPU` read 0, and writes to them are dropped.
- R11: A pending bit is set only on a low-to-high transition of its line, as sampled on `clk`. A line held high does not set it again after a clear. If a set and a clear hit the same bit in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| irq_in | input | 16 | Request lines; bit 0 unused |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the 256-byte window, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ack_valid | input | 1 | Processor acknowledges an interrupt |
| ack_num | input | 4 | Number of the acknowledged interrupt |
| irq_level | output | 4 | Encoded interrupt level to the processor |
| irq_req | output | 1 | High when `irq_level` is non-zero |

## Verification
A pending or force bit that is wrong shows up at `irq_level` one clock after the state is written, provided the line is unmasked. It can also be read back through the bus in the cycle after the write. A wrong group bit is exposed only when the high and low groups are both non-empty, so the bench builds that case on purpose. A stale broadcast route leaves pending set where it should be clear, and a read of another CPU's force word shows the missing copy at once.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int unsigned LINES   = 16;
    localparam int unsigned IDX_W   = $clog2(LINES);
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned EXT_W   = 4;
    localparam int unsigned MAX_CPU = 16;

    // line 0 does not exist
    localparam logic [LINES-1:0] LINE_MASK = {{(LINES-1){1'b1}}, 1'b0};

    typedef logic [LINES-1:0] vec_t;

    typedef enum logic [3:0] {
        K_GROUP,
        K_PEND,
        K_ALIAS,
        K_CLEAR,
        K_STATUS,
        K_BCAST,
        K_MASK,
        K_FORCE,
        K_EXT,
        K_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] cpu;
        logic       cpu_ok;
    } dec_t;

endpackage

// File: rtl/pic_edge_det.sv
module pic_edge_det #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_in,
    output logic [W-1:0] rise
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = req_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign rise = req_in & ~prev_q;

endmodule

// File: rtl/pic_highest.sv
module pic_highest #(
    parameter int unsigned W     = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx
);

    // later iterations overwrite: the highest set bit wins
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/pic_level_sel.sv
module pic_level_sel #(
    parameter int unsigned W     = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     active,
    input  logic [W-1:0]     hi_sel,
    output logic [IDX_W-1:0] level
);

    logic [W-1:0]     hi_vec, lo_vec;
    logic [IDX_W-1:0] hi_idx, lo_idx;
    logic [IDX_W-1:0] lvl_d, lvl_q;

    assign hi_vec = active & hi_sel;
    assign lo_vec = active & ~hi_sel;

    pic_highest #(.W(W), .IDX_W(IDX_W)) u_hi (.vec(hi_vec), .idx(hi_idx));
    pic_highest #(.W(W), .IDX_W(IDX_W)) u_lo (.vec(lo_vec), .idx(lo_idx));

    always_comb begin
        lvl_d = (|hi_vec) ? hi_idx : lo_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign level = lvl_q;

endmodule

// File: rtl/pic_addr_dec.sv
module pic_addr_dec
    import prio_irq_pkg::*;
#(
    parameter int unsigned NCPU = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        dec.kind   = K_NONE;
        dec.cpu    = addr[5:2];
        dec.cpu_ok = (32'(addr[5:2]) < NCPU);
        if (addr[1:0] == 2'b00) begin
            unique case (addr[7:6])
                2'b00: begin
                    case (addr[5:2])
                        4'd0:    dec.kind = K_GROUP;
                        4'd1:    dec.kind = K_PEND;
                        4'd2:    dec.kind = K_ALIAS;
                        4'd3:    dec.kind = K_CLEAR;
                        4'd4:    dec.kind = K_STATUS;
                        4'd5:    dec.kind = K_BCAST;
                        default: dec.kind = K_NONE;
                    endcase
                end
                2'b01:   dec.kind = K_MASK;
                2'b10:   dec.kind = K_FORCE;
                default: dec.kind = K_EXT;
            endcase
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int unsigned NCPU = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_in,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ack_valid,
    input  logic [IDX_W-1:0]  ack_num,
    output logic [IDX_W-1:0]  irq_level,
    output logic              irq_req
);

    typedef struct packed {
        vec_t                             group;
        vec_t                             pend;
        vec_t                             bcast;
        logic [NCPU-1:0][DATA_W-1:0]      mask;
        logic [NCPU-1:0][LINES-1:0]       frc;
        logic [NCPU-1:0][EXT_W-1:0]       ext;
    } state_t;

    state_t st_d, st_q;
    dec_t   dec;
    vec_t   rise, rise_m, clr_vec, f_set, f_clr;
    logic   wr;

    // signals shared with the bound checker
    vec_t   pend_w, frc0_w, bcast_w, active_w;

    pic_edge_det #(.W(LINES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (irq_in),
        .rise   (rise)
    );

    pic_addr_dec #(.NCPU(NCPU)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    always_comb begin
        wr     = bus_sel & bus_we;
        rise_m = rise & LINE_MASK;
        f_set  = bus_wdata[LINES-1:0] & LINE_MASK;
        f_clr  = bus_wdata[DATA_W-1:LINES] & LINE_MASK;

        clr_vec = '0;
        if (wr && dec.kind == K_CLEAR) clr_vec = f_set;
        if (ack_valid) clr_vec = clr_vec | (LINE_MASK & (vec_t'(1) << ack_num));

        st_d = st_q;
        if (wr) begin
            case (dec.kind)
                K_GROUP: st_d.group  = f_set;
                K_BCAST: st_d.bcast  = f_set;
                K_ALIAS: st_d.frc[0] = f_set;
                K_MASK: begin
                    for (int c = 0; c < NCPU; c++) begin
                        if (dec.cpu_ok && dec.cpu == 4'(c))
                            st_d.mask[c] = bus_wdata & ~DATA_W'(1);
                    end
                end
                K_FORCE: begin
                    for (int c = 0; c < NCPU; c++) begin
                        if (dec.cpu_ok && dec.cpu == 4'(c))
                            st_d.frc[c] = (st_q.frc[c] | f_set) & ~f_clr;
                    end
                end
                K_EXT: begin
                    for (int c = 0; c < NCPU; c++) begin
                        if (dec.cpu_ok && dec.cpu == 4'(c))
                            st_d.ext[c] = bus_wdata[EXT_W-1:0];
                    end
                end
                default: ;
            endcase
        end

        // clears first, then sets, so a same-cycle set survives
        st_d.pend   = st_d.pend & ~clr_vec;
        st_d.frc[0] = st_d.frc[0] & ~clr_vec;
        st_d.pend   = st_d.pend | (rise_m & ~st_q.bcast);
        for (int c = 0; c < NCPU; c++) begin
            st_d.frc[c] = st_d.frc[c] | (rise_m & st_q.bcast);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (dec.kind)
            K_GROUP: bus_rdata = DATA_W'(st_q.group);
            K_PEND:  bus_rdata = DATA_W'(st_q.pend);
            K_ALIAS: bus_rdata = DATA_W'(st_q.frc[0]);
            K_BCAST: bus_rdata = DATA_W'(st_q.bcast);
            K_MASK: begin
                for (int c = 0; c < NCPU; c++) begin
                    if (dec.cpu_ok && dec.cpu == 4'(c)) bus_rdata = st_q.mask[c];
                end
            end
            K_FORCE: begin
                for (int c = 0; c < NCPU; c++) begin
                    if (dec.cpu_ok && dec.cpu == 4'(c)) bus_rdata = DATA_W'(st_q.frc[c]);
                end
            end
            K_EXT: begin
                for (int c = 0; c < NCPU; c++) begin
                    if (dec.cpu_ok && dec.cpu == 4'(c)) bus_rdata = DATA_W'(st_q.ext[c]);
                end
            end
            default: bus_rdata = '0;
        endcase
    end

    assign pend_w   = st_q.pend;
    assign frc0_w   = st_q.frc[0];
    assign bcast_w  = st_q.bcast;
    assign active_w = (pend_w | frc0_w) & st_q.mask[0][LINES-1:0];

    pic_level_sel #(.W(LINES), .IDX_W(IDX_W)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active_w),
        .hi_sel (st_q.group),
        .level  (irq_level)
    );

    assign irq_req = (irq_level != '0);

endmodule

// File: rtl/pic_checker.sv
module pic_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_rdata,
    input logic        ack_valid,
    input logic [3:0]  ack_num,
    input logic [3:0]  irq_level,
    input logic [15:0] rise,
    input logic [15:0] pend,
    input logic [15:0] frc0,
    input logic [15:0] bcast,
    input logic [15:0] active
);

    logic [15:0] rise_p, rise_b;
    assign rise_p = rise & ~bcast & 16'hFFFE;
    assign rise_b = rise & bcast & 16'hFFFE;

    p_rdata_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr[7:6] != 2'b11) |-> (bus_rdata[0] == 1'b0));

    p_pend_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 8'h04 && rise == 16'h0 && !ack_valid)
        |=> $stable(pend));

    p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) == 16'h0) |-> (irq_level == 4'd0));

    p_level_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != 4'd0) |-> ((($past(active) >> irq_level) & 16'h1) != 16'h0));

    p_bcast_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_b != 16'h0) |=> ((frc0 & $past(rise_b)) == $past(rise_b)));

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_num != 4'd0 && !rise[ack_num] && !(bus_sel && bus_we))
        |=> (!pend[$past(ack_num)] && !frc0[$past(ack_num)]));

    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_p != 16'h0) |=> ((pend & $past(rise_p)) == $past(rise_p)));

endmodule

bind prio_irq_ctrl pic_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .ack_valid (ack_valid),
    .ack_num   (ack_num),
    .irq_level (irq_level),
    .rise      (rise),
    .pend      (pend_w),
    .frc0      (frc0_w),
    .bcast     (bcast_w),
    .active    (active_w)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_num = '0;
    logic [3:0]  irq_level;
    logic        irq_req;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    prio_irq_ctrl #(.NCPU(4)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_valid(ack_valid), .ack_num(ack_num),
        .irq_level(irq_level), .irq_req(irq_req)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IRQ = 2'd2, OP_ACK = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp_rd;
        logic [3:0]  exp_lvl;
        logic [3:0]  req;
    } tv_t;

    localparam int NV = 31;
    localparam tv_t VECS [NV] = '{
        '{OP_WR,  8'h40, 32'hFFFF_FFFF, 32'h0,         4'd0,  4'd2},  // R2 mask0 all
        '{OP_RD,  8'h40, 32'h0,         32'hFFFF_FFFE, 4'd0,  4'd2},  // R2 bit0 dropped
        '{OP_IRQ, 8'h00, 32'h0000_0029, 32'h0,         4'd5,  4'd11}, // R11 lines 0,3,5 rise
        '{OP_RD,  8'h04, 32'h0,         32'h0000_0028, 4'd5,  4'd2},  // R2 line 0 not latched
        '{OP_WR,  8'h00, 32'h0000_0009, 32'h0,         4'd3,  4'd7},  // R7 line 3 high group
        '{OP_RD,  8'h00, 32'h0,         32'h0000_0008, 4'd3,  4'd7},
        '{OP_WR,  8'h04, 32'h0000_FFFF, 32'h0,         4'd3,  4'd3},  // R3 pending write ignored
        '{OP_RD,  8'h04, 32'h0,         32'h0000_0028, 4'd3,  4'd3},
        '{OP_ACK, 8'h00, 32'h0000_0003, 32'h0,         4'd5,  4'd9},  // R9 ack 3
        '{OP_WR,  8'h0C, 32'h0000_0021, 32'h0,         4'd0,  4'd4},  // R4 clear 5
        '{OP_RD,  8'h0C, 32'h0,         32'h0,         4'd0,  4'd3},  // R3 clear reads 0
        '{OP_RD,  8'h10, 32'h0,         32'h0,         4'd0,  4'd3},  // R3 status reads 0
        '{OP_WR,  8'h80, 32'h0000_0402, 32'h0,         4'd10, 4'd5},  // R5 set 10,1
        '{OP_WR,  8'h80, 32'h0400_0000, 32'h0,         4'd1,  4'd5},  // R5 clear 10
        '{OP_RD,  8'h08, 32'h0,         32'h0000_0002, 4'd1,  4'd6},  // R6 alias read
        '{OP_WR,  8'h08, 32'h0000_8001, 32'h0,         4'd15, 4'd6},  // R6 replace
        '{OP_RD,  8'h80, 32'h0,         32'h0000_8000, 4'd15, 4'd6},
        '{OP_WR,  8'h40, 32'h0000_7FFE, 32'h0,         4'd0,  4'd7},  // R7 mask hides 15
        '{OP_WR,  8'h14, 32'h0000_0041, 32'h0,         4'd0,  4'd8},  // R8 broadcast 6
        '{OP_RD,  8'h14, 32'h0,         32'h0000_0040, 4'd0,  4'd8},
        '{OP_IRQ, 8'h00, 32'h0000_0040, 32'h0,         4'd6,  4'd8},  // R8 line 6 to forces
        '{OP_RD,  8'h04, 32'h0,         32'h0,         4'd6,  4'd8},  // R8 pending untouched
        '{OP_RD,  8'h8C, 32'h0,         32'h0000_0040, 4'd6,  4'd8},  // R8 cpu3 force
        '{OP_WR,  8'h8C, 32'h0040_0040, 32'h0,         4'd6,  4'd5},  // R5 clear beats set
        '{OP_RD,  8'h8C, 32'h0,         32'h0,         4'd6,  4'd5},
        '{OP_WR,  8'hC4, 32'hFFFF_FFFF, 32'h0,         4'd6,  4'd10}, // R10 extended
        '{OP_RD,  8'hC4, 32'h0,         32'h0000_000F, 4'd6,  4'd10},
        '{OP_WR,  8'h50, 32'hFFFF_FFFF, 32'h0,         4'd6,  4'd10}, // R10 absent cpu4
        '{OP_RD,  8'h50, 32'h0,         32'h0,         4'd6,  4'd10},
        '{OP_WR,  8'h0C, 32'h0000_8040, 32'h0,         4'd0,  4'd4},  // R4 clears force0
        '{OP_RD,  8'h08, 32'h0,         32'h0,         4'd0,  4'd4}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_lvl(input string tag, input logic [3:0] exp);
        chk({tag, " level"}, 32'(irq_level), 32'(exp));
        chk({tag, " req"}, 32'(irq_req), 32'(exp != 4'd0));
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk_lvl("R1 reset", 4'd0);
        rd_chk("R1 group", 8'h00, 32'h0);
        rd_chk("R1 pending", 8'h04, 32'h0);
        rd_chk("R1 broadcast", 8'h14, 32'h0);
        rd_chk("R1 mask0", 8'h40, 32'h0);
        rd_chk("R1 force0", 8'h80, 32'h0);
        rd_chk("R1 ext0", 8'hC0, 32'h0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec %0d", VECS[i].req, i);
            case (VECS[i].op)
                OP_WR: begin
                    bus_write(VECS[i].addr, VECS[i].data);
                    @(negedge clk);
                end
                OP_RD: rd_chk(tag, VECS[i].addr, VECS[i].exp_rd);
                OP_IRQ: begin
                    @(negedge clk); irq_in = VECS[i].data[15:0];
                    @(negedge clk); irq_in = '0;
                    @(negedge clk);
                end
                default: begin
                    @(negedge clk); ack_valid = 1'b1; ack_num = VECS[i].data[3:0];
                    @(negedge clk); ack_valid = 1'b0;
                    @(negedge clk);
                end
            endcase
            chk_lvl(tag, VECS[i].exp_lvl);
        end

        // R11: rise and clear of line 9 in one cycle, set wins
        @(negedge clk);
        irq_in = 16'h0200;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h0000_0200;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; irq_in = '0;
        rd_chk("R11 set beats clear", 8'h04, 32'h0000_0200);
        chk_lvl("R11 set beats clear", 4'd9);

        // R11: held-high line does not set pending again
        @(negedge clk); irq_in = 16'h0200;
        bus_write(8'h0C, 32'h0000_0200);
        repeat (3) @(negedge clk);
        rd_chk("R11 held line", 8'h04, 32'h0);
        chk_lvl("R11 held line", 4'd0);
        @(negedge clk); irq_in = '0;

        // R9: ack removes a forced line
        bus_write(8'h80, 32'h0000_0010);
        @(negedge clk);
        chk_lvl("R9 forced 4", 4'd4);
        @(negedge clk); ack_valid = 1'b1; ack_num = 4'd4;
        @(negedge clk); ack_valid = 1'b0;
        @(negedge clk);
        chk_lvl("R9 ack 4", 4'd0);
        rd_chk("R9 force0 after ack", 8'h08, 32'h0);

        // R1: reset in mid-run
        bus_write(8'h00, 32'h0000_FFFE);
        @(negedge clk); irq_in = 16'h0400;
        @(negedge clk); irq_in = '0;
        @(negedge clk);
        chk_lvl("R1 before reset", 4'd10);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk_lvl("R1 after reset", 4'd0);
        rd_chk("R1 group after reset", 8'h00, 32'h0);
        rd_chk("R1 pending after reset", 8'h04, 32'h0);
        rd_chk("R1 mask after reset", 8'h40, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule